// File: doc/BRIEF.md
# Saturating Delay Tap Walker

This block owns the tap setting of one programmable input or output delay element. The requested move is presented as a 16-bit unsigned step count and a direction flag, with the direction flag set to 1 for increment and 0 for decrement. A one-cycle strobe starts the move. The block then walks the tap one position per clock. It drives a step-enable pulse and a step-direction bit toward the delay element, and it keeps its own copy of the applied tap value, which it shows on a readback port.

The tap range is 0 to 511. A walk that would cross either end stops at that end without reporting an error, and the block declares completion as soon as no further movement is possible. A done flag reports completion and stays high until the next accepted strobe. Separate instances can serve a transmit line and a receive line.

Top module: `tapwalk_ctrl`

## Requirements
- R1: While synchronous reset is high, and after it is released, the tap readback is 0, busy is 0, done is 1 and step enable is 0.
- R2: A strobe sampled while the block is not busy is accepted on that clock edge. From the next cycle busy is 1 and done is 0.
- R3: While walking, the block issues at most one step per cycle. Each step is a one-cycle step-enable pulse, with step direction equal to the captured direction flag, and each pulse moves the readback by exactly one.
- R4: If the strobe edge is called edge 0 and no limit is met, a request of N steps changes the readback by exactly N. The last tap change lands on edge N, and done rises on edge N+1.
- R5: Increment steps stop at tap 511. The readback never exceeds 511, and a walk that meets 511 finishes one edge after its last effective step.
- R6: Decrement steps stop at tap 0. The readback never wraps, and a walk that meets 0 finishes one edge after its last effective step.
- R7: A step count of zero leaves the readback unchanged, and done returns on edge 1 after being low for one cycle.
- R8: A strobe sampled while busy is ignored. This includes the edge on which the walk finishes, so busy stays 0 afterwards.
- R9: Once done is high, it and the readback stay constant until the next accepted strobe.
- R10: Changes to the step count or direction inputs after the strobe has been accepted have no effect on the walk in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| strobe_i | input | 1 | Starts an adjustment when the block is idle |
| steps_i | input | 16 | Requested number of tap steps, unsigned |
| dir_up_i | input | 1 | 1 = increment the tap, 0 = decrement it |
| step_en_o | output | 1 | One-cycle pulse per tap step toward the delay element |
| step_up_o | output | 1 | Direction of the current step, 1 = up |
| tap_o | output | 9 | Applied tap value readback |
| busy_o | output | 1 | A walk is in progress |
| done_o | output | 1 | Last adjustment finished |

## Verification
Three events can land on the same clock edge. The step count can run out on the same edge that the tap reaches a limit, and a new strobe can arrive on the same edge that a walk completes. The bench covers the first case with step counts chosen to end exactly at 0 or 511, and with longer counts that run past the limit. It covers the second by holding the strobe high, with scrambled count and direction, through every busy cycle of some walks, including the finishing edge. Each walk is then judged on three things: the tap value computed as a clamped sum, the number of step pulses, and the cycle on which done rises. The bench also confirms that busy stays low after done rises.

// File: rtl/tapwalk_pkg.sv
package tapwalk_pkg;
  typedef enum logic [0:0] {
    WALK_IDLE = 1'b0,
    WALK_RUN  = 1'b1
  } walk_state_e;
endpackage

// File: rtl/tapwalk_handshake.sv
module tapwalk_handshake
  import tapwalk_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  input  logic fin,
  output logic accept,
  output logic busy,
  output logic done
);
  walk_state_e state;

  assign busy   = (state == WALK_RUN);
  assign accept = strobe && (state == WALK_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= WALK_IDLE;
      done  <= 1'b1;
    end else begin
      unique case (state)
        WALK_IDLE: if (strobe) begin
          state <= WALK_RUN;
          done  <= 1'b0;
        end
        WALK_RUN: if (fin) begin
          state <= WALK_IDLE;
          done  <= 1'b1;
        end
        default: state <= WALK_IDLE;
      endcase
    end
  end

  // R2
  accept_start_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe && !busy) |=> (busy && !done));
  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !strobe) |=> done);
  // R8
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !fin) |=> busy);
  // R1
  done_busy_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(done && busy));
endmodule

// File: rtl/tapwalk_remain.sv
module tapwalk_remain #(
  parameter int STEP_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [STEP_W-1:0] load_val,
  input  logic              dec,
  output logic              rem_zero
);
  logic [STEP_W-1:0] rem;

  function automatic logic [STEP_W-1:0] rem_next(input logic [STEP_W-1:0] r);
    return r - STEP_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst)       rem <= '0;
    else if (load) rem <= load_val;
    else if (dec)  rem <= rem_next(rem);
  end

  assign rem_zero = (rem == '0);

  // R4
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    dec |-> !rem_zero);
  // R10
  rem_count_chk: assert property (@(posedge clk) disable iff (rst)
    (dec && !load) |=> (rem == $past(rem) - STEP_W'(1)));
  // R10
  rem_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!dec && !load) |=> $stable(rem));
endmodule

// File: rtl/tapwalk_tap.sv
module tapwalk_tap #(
  parameter int TAP_W   = 9,
  parameter int TAP_MAX = 511
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_en,
  input  logic             step_up,
  output logic [TAP_W-1:0] tap,
  output logic             at_lim
);
  localparam logic [TAP_W-1:0] TOP_TAP = TAP_W'(TAP_MAX);

  logic at_top;
  logic at_bot;

  generate
    if (TAP_MAX == (1 << TAP_W) - 1) begin : g_full_range
      assign at_top = &tap;
    end else begin : g_part_range
      assign at_top = (tap == TOP_TAP);
    end
  endgenerate

  assign at_bot = (tap == '0);
  assign at_lim = step_up ? at_top : at_bot;

  function automatic logic [TAP_W-1:0] tap_after(input logic [TAP_W-1:0] t,
                                                  input logic up);
    return up ? t + TAP_W'(1) : t - TAP_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst)          tap <= '0;
    else if (step_en) tap <= tap_after(tap, step_up);
  end

  // R5
  upper_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (step_en && step_up) |-> (tap != TOP_TAP));
  // R6
  lower_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (step_en && !step_up) |-> (tap != '0));
  // R3
  tap_up_chk: assert property (@(posedge clk) disable iff (rst)
    (step_en && step_up) |=> (tap == $past(tap) + TAP_W'(1)));
  // R3
  tap_down_chk: assert property (@(posedge clk) disable iff (rst)
    (step_en && !step_up) |=> (tap == $past(tap) - TAP_W'(1)));
  // R9
  tap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> $stable(tap));
endmodule

// File: rtl/tapwalk_ctrl.sv
module tapwalk_ctrl #(
  parameter int STEP_W  = 16,
  parameter int TAP_W   = 9,
  parameter int TAP_MAX = 511
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe_i,
  input  logic [STEP_W-1:0] steps_i,
  input  logic              dir_up_i,
  output logic              step_en_o,
  output logic              step_up_o,
  output logic [TAP_W-1:0]  tap_o,
  output logic              busy_o,
  output logic              done_o
);
  logic accept;
  logic busy;
  logic done;
  logic fin;
  logic rem_zero;
  logic at_lim;
  logic dir_q;
  logic step_fire;

  always_ff @(posedge clk) begin
    if (rst)         dir_q <= 1'b1;
    else if (accept) dir_q <= dir_up_i;
  end

  assign fin       = busy && (rem_zero || at_lim);
  assign step_fire = busy && !fin;

  tapwalk_handshake u_hs (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe_i),
    .fin    (fin),
    .accept (accept),
    .busy   (busy),
    .done   (done)
  );

  tapwalk_remain #(.STEP_W(STEP_W)) u_rem (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .load_val (steps_i),
    .dec      (step_fire),
    .rem_zero (rem_zero)
  );

  tapwalk_tap #(.TAP_W(TAP_W), .TAP_MAX(TAP_MAX)) u_tap (
    .clk     (clk),
    .rst     (rst),
    .step_en (step_fire),
    .step_up (dir_q),
    .tap     (tap_o),
    .at_lim  (at_lim)
  );

  assign step_en_o = step_fire;
  assign step_up_o = dir_q;
  assign busy_o    = busy;
  assign done_o    = done;

  // R10
  dir_stable_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(dir_q) || !busy_o);
  // R3
  step_busy_chk: assert property (@(posedge clk) disable iff (rst)
    step_en_o |-> busy_o);
endmodule

// File: tb/tapwalk_ctrl_test.sv
module tapwalk_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        strobe_i = 1'b0;
  logic [15:0] steps_i = '0;
  logic        dir_up_i = 1'b1;
  logic        step_en_o, step_up_o, busy_o, done_o;
  logic [8:0]  tap_o;

  int n_cmp = 0;
  int n_bad = 0;
  int model_tap = 0;

  always #5 clk = ~clk;

  tapwalk_ctrl uut (
    .clk(clk), .rst(rst), .strobe_i(strobe_i), .steps_i(steps_i),
    .dir_up_i(dir_up_i), .step_en_o(step_en_o), .step_up_o(step_up_o),
    .tap_o(tap_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic string walk_tag(input int n, input int eff, input bit up);
    if (n == 0) return "R7";
    if (eff < n) return up ? "R5" : "R6";
    return "R4";
  endfunction

  task automatic walk(input int n, input bit up, input bit noise);
    int eff, cyc, pulses, dir_bad, start;
    string tg;
    start = model_tap;
    if (up) eff = (n < 511 - model_tap) ? n : 511 - model_tap;
    else    eff = (n < model_tap) ? n : model_tap;
    tg = walk_tag(n, eff, up);
    @(negedge clk);
    strobe_i = 1'b1; steps_i = 16'(n); dir_up_i = up;
    @(negedge clk);
    check("R2", "busy after strobe", int'(busy_o), 1);
    check("R2", "done after strobe", int'(done_o), 0);
    pulses = 0; dir_bad = 0; cyc = 0;
    if (step_en_o) begin
      pulses++;
      if (step_up_o != up) dir_bad++;
    end
    strobe_i = noise;
    steps_i  = noise ? ~16'(n) : 16'(n);
    dir_up_i = noise ? ~up : up;
    forever begin
      @(negedge clk);
      cyc++;
      if (done_o || cyc > 70000) break;
      if (step_en_o) begin
        pulses++;
        if (step_up_o != up) dir_bad++;
      end
      strobe_i = noise;
      steps_i  = 16'(cyc * 977);
      dir_up_i = noise ? ~up : up;
    end
    strobe_i = 1'b0;
    model_tap = start + (up ? eff : -eff);
    check(tg, "done cycle", cyc, eff + 1);
    check("R3", "step pulses", pulses, eff);
    check("R3", "step direction errors", dir_bad, 0);
    check(noise ? "R10" : tg, "tap after walk", int'(tap_o), model_tap);
    @(negedge clk);
    @(negedge clk);
    check(noise ? "R8" : "R9", "busy after done", int'(busy_o), 0);
    check("R9", "done held", int'(done_o), 1);
    check("R9", "tap held", int'(tap_o), model_tap);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "tap in reset", int'(tap_o), 0);
    check("R1", "busy in reset", int'(busy_o), 0);
    check("R1", "done in reset", int'(done_o), 1);
    check("R1", "step_en in reset", int'(step_en_o), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "tap after reset", int'(tap_o), 0);
    check("R1", "done after reset", int'(done_o), 1);
    for (int n = 0; n <= 12; n++) walk(n, 1'b1, (n % 3) == 0);
    for (int n = 0; n <= 12; n++) walk(n, 1'b0, (n % 4) == 1);
    walk(600, 1'b1, 1'b0);
    walk(5, 1'b1, 1'b1);
    walk(0, 1'b1, 1'b0);
    walk(11, 1'b0, 1'b0);
    walk(11, 1'b1, 1'b1);
    walk(65535, 1'b0, 1'b1);
    walk(3, 1'b0, 1'b0);
    walk(511, 1'b1, 1'b0);
    walk(511, 1'b0, 1'b1);
    for (int n = 1; n <= 40; n += 3) walk(n * 7, (n % 2) == 1, (n % 5) == 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule